// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Receiver

This block receives a two-channel audio stream on three wires: a bit clock, a left/right word clock and a serial data line. It delivers each stereo pair as two parallel 24-bit samples and a one-cycle valid strobe. All three serial inputs are oversampled by a faster system clock, so the bit clock can run in bursts or stop between bits. A static 2-bit format input picks one of four framings: right-justified, I2S, left-justified or DSP frame-pulse. A second static input picks the word length. Data arrives MSB first in two's complement, and every captured word is sign-extended to 24 bits.

For each channel a zero detector counts consecutive frames whose sample is exactly zero. It raises a flag once the run exceeds a parameterised number of frames. The first non-zero sample on that channel clears the flag.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and right after it, `left_o`, `right_o`, `valid_o`, `zero_left_o` and `zero_right_o` are all zero.
- R2: With `fmt_i` = 00 (right-justified), a high word clock marks the left channel. The N bits sampled just before each word-clock transition form the word of the half that is ending, and earlier bits in that half are ignored.
- R3: With `fmt_i` = 01 (I2S), a low word clock marks the left channel. The MSB is the second bit sampled after a word-clock transition, and the N-1 bits after it follow.
- R4: With `fmt_i` = 10 (left-justified), a high word clock marks the left channel. The MSB is the first bit sampled after a word-clock transition.
- R5: With `fmt_i` = 11 (DSP), the bit at which the word clock is first sampled high is frame slot 0. The left word occupies the N slots after it and the right word the N slots after that.
- R6: `wlen_i` selects N: 00 = 16, 01 = 18, 10 = 20, 11 = 24 bits. Bits outside the selected slots are ignored, and each word appears on its output sign-extended from bit N-1 to bit 23.
- R7: Data and word clock are sampled at rising bit-clock edges. After the right word's last bit, `valid_o` pulses for one system clock with both words of the pair. The outputs hold their values between pulses.
- R8: The bit clock may pause low for any number of system clocks between bits without changing any result. Each bit-clock phase must last at least two system clocks.
- R9: A channel's zero flag goes high at the end of the frame that makes the run of consecutive all-zero samples on that channel longer than `ZERO_FRAMES`, and not before.
- R10: A channel's zero flag clears at the first frame whose sample on that channel is non-zero, and this restarts the run count. The two channels are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock, may be gated |
| lrck_i | input | 1 | Left/right word clock or frame pulse |
| sdata_i | input | 1 | Serial audio data, MSB first |
| fmt_i | input | 2 | Framing select: 00 RJ, 01 I2S, 10 LJ, 11 DSP |
| wlen_i | input | 2 | Word length select: 16/18/20/24 bits |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| zero_left_o | output | 1 | Left channel long-silence flag |
| zero_right_o | output | 1 | Right channel long-silence flag |

## Verification
The assertions assume that the format and word-length inputs change only while reset is held. They also assume that each bit-clock phase spans at least two system clocks, which keeps synchronised bit events two or more cycles apart. The stimulus meets both conditions: it reprograms the configuration only under reset, and it drives each bit as two clocks low and two clocks high. Gated stretches only lengthen the low phase. Every framing has 32 bit slots per channel, and the filler bits in those slots differ from the data, so a capture window that is off by one slot gives a wrong word.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

   localparam int SAMPLE_W = 24;

   typedef enum logic [1:0] {
      FMT_RJ  = 2'b00,
      FMT_I2S = 2'b01,
      FMT_LJ  = 2'b10,
      FMT_DSP = 2'b11
   } fmt_e;

   // Word length in bits for a word-length select code.
   function automatic int unsigned word_bits(input logic [1:0] sel);
      case (sel)
         2'b00:   return 16;
         2'b01:   return 18;
         2'b10:   return 20;
         default: return 24;
      endcase
   endfunction

   // Keep the low N bits and replicate bit N-1 upward.
   function automatic logic [SAMPLE_W-1:0] sign_extend(input logic [SAMPLE_W-1:0] raw,
                                                      input logic [1:0] sel);
      int unsigned n;
      logic [SAMPLE_W-1:0] r;
      n = word_bits(sel);
      for (int i = 0; i < SAMPLE_W; i++) begin
         r[i] = (i < int'(n)) ? raw[i] : raw[n-1];
      end
      return r;
   endfunction

endpackage

// File: rtl/audrx_sync.sv
module audrx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic lrck_i,
   input  logic sdata_i,
   output logic bit_evt_o,
   output logic lr_o,
   output logic data_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("audrx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sc_q, lr_q, sd_q;
   logic              sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sc_q   <= '0;
         lr_q   <= '0;
         sd_q   <= '0;
         sclk_d <= 1'b0;
      end else begin
         sc_q   <= {sc_q[STAGES-2:0], sclk_i};
         lr_q   <= {lr_q[STAGES-2:0], lrck_i};
         sd_q   <= {sd_q[STAGES-2:0], sdata_i};
         sclk_d <= sc_q[STAGES-1];
      end
   end

   assign bit_evt_o = sc_q[STAGES-1] & ~sclk_d;
   assign lr_o      = lr_q[STAGES-1];
   assign data_o    = sd_q[STAGES-1];

   // R8: a high bit-clock phase lasts at least two system clocks
   a_r8_sclk_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sc_q[STAGES-1]) |=> sc_q[STAGES-1]);

   // R8: a low bit-clock phase lasts at least two system clocks
   a_r8_sclk_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sc_q[STAGES-1]) |=> !sc_q[STAGES-1]);

endmodule

// File: rtl/audrx_framer.sv
module audrx_framer
   import audrx_pkg::*;
#(
   parameter int POS_W = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          fmt_i,
   input  logic [1:0]          wsel_i,
   input  logic                bit_evt_i,
   input  logic                lr_i,
   input  logic                din_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);

   localparam logic [POS_W-1:0] POS_MAX = '1;

   if ((2 ** POS_W) <= (2 * SAMPLE_W + 2)) begin : g_bad_pos
      $error("audrx_framer: POS_W too small for two words plus offset");
   end

   logic                prev_lr, armed, locked;
   logic [POS_W-1:0]    pos_q;
   logic [SAMPLE_W-1:0] sreg_q, left_hold_q, left_q, right_q;
   logic                valid_q;

   logic                is_rj, is_dsp, is_lj, start;
   logic [POS_W-1:0]    pos_now, nbits, off, first_end, second_end;
   logic [SAMPLE_W-1:0] shifted, word_slot, word_rj;
   logic                first_done, second_done, chan_left;
   logic                cap_left, cap_right, rj_cap;

   always_comb begin
      is_rj   = (fmt_i == FMT_RJ);
      is_dsp  = (fmt_i == FMT_DSP);
      is_lj   = (fmt_i == FMT_LJ);
      start   = armed & (is_dsp ? (lr_i & ~prev_lr) : (lr_i ^ prev_lr));
      pos_now = start ? '0 : ((pos_q == POS_MAX) ? POS_MAX : pos_q + 1'b1);
      nbits   = POS_W'(word_bits(wsel_i));
      off     = (is_lj || is_rj) ? '0 : POS_W'(1);
      first_end  = off + nbits - 1'b1;
      second_end = off + nbits + nbits - 1'b1;
      shifted    = {sreg_q[SAMPLE_W-2:0], din_i};
      word_slot  = sign_extend(shifted, wsel_i);
      word_rj    = sign_extend(sreg_q, wsel_i);
      first_done  = !is_rj && (pos_now == first_end);
      second_done = is_dsp && (pos_now == second_end);
      chan_left   = is_lj ? lr_i : ~lr_i;
      cap_left    = first_done & (is_dsp | chan_left);
      cap_right   = (first_done & !is_dsp & !chan_left) | second_done;
      rj_cap      = is_rj & start & locked;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lr     <= 1'b0;
         armed       <= 1'b0;
         locked      <= 1'b0;
         pos_q       <= POS_MAX;
         sreg_q      <= '0;
         left_hold_q <= '0;
         left_q      <= '0;
         right_q     <= '0;
         valid_q     <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (bit_evt_i) begin
            prev_lr <= lr_i;
            armed   <= 1'b1;
            pos_q   <= pos_now;
            sreg_q  <= shifted;
            if (start) locked <= 1'b1;
            if (cap_left) left_hold_q <= word_slot;
            if (cap_right) begin
               left_q  <= left_hold_q;
               right_q <= word_slot;
               valid_q <= 1'b1;
            end
            if (rj_cap) begin
               if (prev_lr) begin
                  left_hold_q <= word_rj;
               end else begin
                  left_q  <= left_hold_q;
                  right_q <= word_rj;
                  valid_q <= 1'b1;
               end
            end
         end
      end
   end

   assign left_o  = left_q;
   assign right_o = right_q;
   assign valid_o = valid_q;

   // R7: the strobe lasts exactly one system clock
   a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R7: samples change only together with the strobe
   a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

   // R7: a pair is only completed by a sampled bit-clock rise
   a_r7_valid_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(bit_evt_i));

endmodule

// File: rtl/audrx_zero.sv
module audrx_zero #(
   parameter int LIMIT = 1024,
   parameter int W     = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         valid_i,
   input  logic [W-1:0] sample_i,
   output logic         flag_o
);

   localparam int CNT_W = $clog2(LIMIT + 2);

   if (LIMIT < 1) begin : g_bad_limit
      $error("audrx_zero: LIMIT must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (valid_i) begin
         if (sample_i == '0) begin
            if (cnt_q <= CNT_W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
            flag_q <= (cnt_q >= CNT_W'(LIMIT));
         end else begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
         end
      end
   end

   assign flag_o = flag_q;

   // R9: the flag only rises at a frame whose sample was zero
   a_r9_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> ($past(valid_i) && ($past(sample_i) == '0)));

   // R10: a non-zero sample clears the flag on the next cycle
   a_r10_clear_on_signal: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (sample_i != '0)) |=> !flag_o);

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
   import audrx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ZERO_FRAMES = 1024,
   parameter int POS_W       = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sclk_i,
   input  logic        lrck_i,
   input  logic        sdata_i,
   input  logic [1:0]  fmt_i,
   input  logic [1:0]  wlen_i,
   output logic [23:0] left_o,
   output logic [23:0] right_o,
   output logic        valid_o,
   output logic        zero_left_o,
   output logic        zero_right_o
);

   localparam int NCH = 2;

   logic                bit_evt, lr_s, data_s, frm_valid;
   logic [SAMPLE_W-1:0] frm_left, frm_right;
   logic [SAMPLE_W-1:0] chan_w [NCH];
   logic [NCH-1:0]      zflag;

   audrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk_i),
      .lrck_i    (lrck_i),
      .sdata_i   (sdata_i),
      .bit_evt_o (bit_evt),
      .lr_o      (lr_s),
      .data_o    (data_s)
   );

   audrx_framer #(.POS_W(POS_W)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt_i     (fmt_i),
      .wsel_i    (wlen_i),
      .bit_evt_i (bit_evt),
      .lr_i      (lr_s),
      .din_i     (data_s),
      .left_o    (frm_left),
      .right_o   (frm_right),
      .valid_o   (frm_valid)
   );

   assign chan_w[0] = frm_left;
   assign chan_w[1] = frm_right;

   for (genvar c = 0; c < NCH; c++) begin : g_zero
      audrx_zero #(.LIMIT(ZERO_FRAMES), .W(SAMPLE_W)) u_zero (
         .clk      (clk),
         .rst_n    (rst_n),
         .valid_i  (frm_valid),
         .sample_i (chan_w[c]),
         .flag_o   (zflag[c])
      );
   end

   assign left_o       = frm_left;
   assign right_o      = frm_right;
   assign valid_o      = frm_valid;
   assign zero_left_o  = zflag[0];
   assign zero_right_o = zflag[1];

endmodule

// File: tb/audio_serial_rx_bench.sv
module audio_serial_rx_bench;

   localparam int ZF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, lrck = 1'b0, sdata = 1'b0;
   logic [1:0]  fmt = 2'b00, wlen = 2'b00;
   logic [23:0] left_o, right_o;
   logic        valid_o, zero_left_o, zero_right_o;

   int checks = 0, errors = 0;
   bit done = 0, clr_cap = 0;
   int ncap = 0;
   logic [23:0] cap_l [16];
   logic [23:0] cap_r [16];
   logic [23:0] exp_l [4];
   logic [23:0] exp_r [4];

   always #4 clk = ~clk;

   audio_serial_rx #(.ZERO_FRAMES(ZF)) u_audio_serial_rx (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .lrck_i(lrck), .sdata_i(sdata),
      .fmt_i(fmt), .wlen_i(wlen), .left_o(left_o), .right_o(right_o),
      .valid_o(valid_o), .zero_left_o(zero_left_o), .zero_right_o(zero_right_o));

   always @(negedge clk) begin
      if (clr_cap) ncap = 0;
      else if (valid_o) begin
         if (ncap < 16) begin
            cap_l[ncap] = left_o;
            cap_r[ncap] = right_o;
         end
         ncap = ncap + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] sext(input logic [23:0] v, input int n);
      logic signed [23:0] t;
      t = v << (24 - n);
      return t >>> (24 - n);
   endfunction

   function automatic int nbits(input logic [1:0] w);
      return (w == 2'b00) ? 16 : (w == 2'b01) ? 18 : (w == 2'b10) ? 20 : 24;
   endfunction

   task automatic send_bit(input logic lr, input logic d, input int gap);
      @(negedge clk);
      lrck = lr; sdata = d;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   // 64 bit slots per frame; filler bits follow an alternating pattern
   task automatic send_frame(input logic [1:0] m, input int n, input logic [23:0] lw,
                             input logic [23:0] rw, input bit burst);
      for (int s = 0; s < 64; s++) begin
         logic lr, d, lvl;
         int k;
         logic [23:0] w;
         int gap;
         gap = (burst && (s % 7 == 3)) ? 9 : 0;
         d = s[0] ^ s[2];
         if (m == 2'b11) begin
            lr = (s == 0);
            if (s >= 1 && s < 1 + n) d = lw[n - s];
            else if (s >= 1 + n && s < 1 + 2 * n) d = rw[2 * n - s];
         end else begin
            k   = s % 32;
            lvl = (m == 2'b01) ? 1'b0 : 1'b1;
            lr  = (s < 32) ? lvl : ~lvl;
            w   = (s < 32) ? lw : rw;
            if (m == 2'b10 && k < n) d = w[n - 1 - k];
            else if (m == 2'b01 && k >= 1 && k <= n) d = w[n - k];
            else if (m == 2'b00 && k >= 32 - n) d = w[31 - k];
         end
         send_bit(lr, d, gap);
      end
   endtask

   task automatic do_reset(input logic [1:0] m, input logic [1:0] w);
      rst_n = 1'b0; fmt = m; wlen = w; sclk = 0; sdata = 0;
      lrck = (m == 2'b01);
      clr_cap = 1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1; clr_cap = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic lead_in(input logic [1:0] m);
      send_bit(m == 2'b01, 1'b1, 0);
      send_bit(m == 2'b01, 1'b0, 0);
   endtask

   function automatic string req_of(input logic [1:0] m);
      case (m)
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R5";
      endcase
   endfunction

   initial begin
      do_reset(2'b00, 2'b00);
      // R1: reset state
      chk(left_o == 0, "R1 left", left_o, 0);
      chk(right_o == 0, "R1 right", right_o, 0);
      chk(valid_o == 0, "R1 valid", valid_o, 0);
      chk(zero_left_o == 0, "R1 zero_l", zero_left_o, 0);
      chk(zero_right_o == 0, "R1 zero_r", zero_right_o, 0);

      // R2 R3 R4 R5 R6 R7 R8: sweep every format and word length
      for (int m = 0; m < 4; m++) begin
         for (int w = 0; w < 4; w++) begin
            int n;
            logic [23:0] mask;
            bit burst;
            n = nbits(w[1:0]);
            mask = (24'h1 << n) - 1;
            burst = ((m + w) % 2) == 1;
            exp_l[0] = (24'h1 << (n - 1)) - 1;
            exp_r[0] = 24'h1 << (n - 1);
            exp_l[1] = (24'h5A5A5A + 24'h1111 * m + 7 * w) & mask;
            exp_r[1] = ~exp_l[1] & mask;
            exp_l[2] = 24'h1;
            exp_r[2] = mask;
            exp_l[3] = (24'h3C3C3 ^ 24'hA5A5A5) & mask;
            exp_r[3] = ((mask >> 1) ^ 24'h1234) & mask;
            do_reset(m[1:0], w[1:0]);
            lead_in(m[1:0]);
            for (int f = 0; f < 4; f++) send_frame(m[1:0], n, exp_l[f], exp_r[f], burst);
            send_frame(m[1:0], n, 24'h0, 24'h0, 1'b0);
            repeat (12) @(negedge clk);
            chk(ncap >= 4, "R7 pair count", ncap, 4);
            for (int f = 0; f < 4; f++) begin
               chk(cap_l[f] == sext(exp_l[f], n), {req_of(m[1:0]), " R6 left"}, cap_l[f], sext(exp_l[f], n));
               chk(cap_r[f] == sext(exp_r[f], n), {req_of(m[1:0]), " R6 right"}, cap_r[f], sext(exp_r[f], n));
            end
         end
      end

      // R9 R10: zero flags, left-justified 16-bit
      do_reset(2'b10, 2'b00);
      lead_in(2'b10);
      for (int f = 0; f < ZF; f++) send_frame(2'b10, 16, 24'h0, 24'h0, 1'b0);
      repeat (12) @(negedge clk);
      chk(zero_left_o == 0, "R9 left at limit", zero_left_o, 0);
      chk(zero_right_o == 0, "R9 right at limit", zero_right_o, 0);
      send_frame(2'b10, 16, 24'h0, 24'h0, 1'b0);
      repeat (12) @(negedge clk);
      chk(zero_left_o == 1, "R9 left past limit", zero_left_o, 1);
      chk(zero_right_o == 1, "R9 right past limit", zero_right_o, 1);
      send_frame(2'b10, 16, 24'h5, 24'h0, 1'b0);
      repeat (12) @(negedge clk);
      chk(zero_left_o == 0, "R10 left cleared", zero_left_o, 0);
      chk(zero_right_o == 1, "R10 right independent", zero_right_o, 1);
      send_frame(2'b10, 16, 24'h0, 24'h0, 1'b0);
      repeat (12) @(negedge clk);
      chk(zero_left_o == 0, "R10 count restarted", zero_left_o, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule